// File: doc/BRIEF.md
# Strobe Timing Window Calibrator

This block calibrates the strobe timing of a DDR memory controller without software. On request it walks a two-dimensional grid. The outer loop steps a coarse write-strobe shift. The inner loop steps a fine read-strobe delay, and that one delay value feeds every byte lane. For each grid point the block does the following:

- It drops the controller start line and programs the settings.
- It acknowledges the controller's error flags.
- It raises start again and waits for the delay line to lock and for memory initialisation to finish.
- It lets the controller settle for a set time.
- It launches an external pattern test.

A grid point passes when the test reports no mismatch and the controller flags no error. Within each coarse shift the block tracks the longest unbroken run of passing delays. The best run found across the whole grid is kept.

Once the grid is finished, the block programs the coarse shift that held the best run. It sets the fine delay to the midpoint of that run and runs one last start sequence. It then raises a done flag, and the chosen shift, delay and run length stay on the result outputs until the next request. If either wait runs past its poll budget, the block stops in a sticky fault state. In that state the settings being tried at the time remain on the shift and delay outputs.

Top module: `dqs_eye_search`

## Requirements
- R1: Trials run in a fixed order. The coarse shift goes from SHIFT_FIRST up to SHIFT_LAST. Within each shift, the fine delay goes from DLY_FIRST up to DLY_LAST. Each grid point is tested exactly once per request, and each test is one `test_go` pulse.
- R2: `out_shift` always equals `wr_shift` plus SHIFT_OFS. Every DW-bit slice of `lane_dly` carries the same delay value.
- R3: `ctl_start` is low in the cycle in which `wr_shift` takes a new value. Every rising edge of `ctl_start` comes one cycle after `err_ack` carried the mask 0x3C for one cycle. `test_go` is only issued while `ctl_start` is high.
- R4: After start is raised, the block waits for `dll_lock` and then for `ctl_status` bit 6. Counting from the cycle in which bit 6 rises, `test_go` appears at the SETTLE+2'th sampling point.
- R5: If either wait sees no response within POLL_MAX cycles, `fatal` sets and stays set until reset. In that case `cal_done` stays low, `wr_shift` and the delay outputs keep the failing trial's values, and `cal_req` is ignored.
- R6: A trial passes only if `test_pass` is high with `test_done` and `ctl_status` bits 5..0 are all zero. Bits 7 and 6 play no part in the verdict. A failing trial ends the current run.
- R7: The run counter restarts at every new coarse shift. A run never spans two shifts.
- R8: A run that is equal to or longer than the best so far replaces it, so among equal runs the later one in sweep order wins.
- R9: After the sweep, `wr_shift` takes the best shift and the delay takes (run start + run end) / 2, rounded down. A final start sequence follows, and `cal_done` rises after its settle time with `ctl_start` left high.
- R10: `res_shift`, `res_dly` and `res_len` hold the chosen values and do not change while `cal_done` is high until `cal_req` arrives. A `cal_req` received during a sweep has no effect.
- R11: If no grid point passes, `cal_done` still rises, with `res_len`, `res_shift`, `res_dly` and the applied shift and delay all zero.
- R12: After reset, `cal_done`, `fatal`, `ctl_start`, `test_go` and all result and setting outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cal_req | input | 1 | Calibration request pulse |
| ctl_start | output | 1 | Controller start level |
| dll_lock | input | 1 | Delay line locked |
| ctl_status | input | STW | Controller status; bit 6 init complete, bits 5..0 errors |
| err_ack | output | STW | One-cycle error acknowledge mask |
| wr_shift | output | SW | Coarse write-strobe shift |
| out_shift | output | SW | Coarse shift plus SHIFT_OFS |
| lane_dly | output | LANES*DW | Fine delay, replicated per lane |
| test_go | output | 1 | Pattern test launch pulse |
| test_done | input | 1 | Pattern test finished |
| test_pass | input | 1 | Pattern test verdict, valid with test_done |
| cal_done | output | 1 | Calibration complete |
| fatal | output | 1 | Sticky poll-timeout fault |
| res_shift | output | SW | Chosen coarse shift |
| res_dly | output | DW | Chosen fine delay |
| res_len | output | DW+1 | Length of the best run |

## Verification
The hardest case to reach is a tie between two runs of equal length. Only the later run may win, and the tie can fall within one shift or across shifts. The bench builds this case from per-point pass maps. It pairs those maps with error-flag maps, which can fail a point even when the pattern test passed, and it keeps bit 7 high throughout as noise. A second hard case is a request that arrives during a sweep. The bench drives one in mid-run and checks that the trial count and the results are unchanged. Stubs that withhold the lock or the init flag drive the block into its fault state.

// File: rtl/dqs_eye_search.sv
module dqs_eye_search #(
  parameter int SHIFT_FIRST = 64,
  parameter int SHIFT_LAST  = 95,
  parameter int SHIFT_OFS   = 32,
  parameter int DLY_FIRST   = 1,
  parameter int DLY_LAST    = 63,
  parameter int LANES       = 9,
  parameter int SW          = 8,
  parameter int DW          = 6,
  parameter int STW         = 8,
  parameter int INIT_BIT    = 6,
  parameter int ERRN        = 6,
  parameter logic [STW-1:0] ACK_MASK = 8'h3C,
  parameter int POLL_MAX    = 65535,
  parameter int SETTLE      = 12500,
  localparam int LW = DW + 1,
  localparam int PW = $clog2(POLL_MAX + 1),
  localparam int TW = $clog2(SETTLE + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cal_req,
  output logic                  ctl_start,
  input  logic                  dll_lock,
  input  logic [STW-1:0]        ctl_status,
  output logic [STW-1:0]        err_ack,
  output logic [SW-1:0]         wr_shift,
  output logic [SW-1:0]         out_shift,
  output logic [LANES*DW-1:0]   lane_dly,
  output logic                  test_go,
  input  logic                  test_done,
  input  logic                  test_pass,
  output logic                  cal_done,
  output logic                  fatal,
  output logic [SW-1:0]         res_shift,
  output logic [DW-1:0]         res_dly,
  output logic [LW-1:0]         res_len
);

  localparam logic [STW-1:0] ERR_BITS = STW'((1 << ERRN) - 1);

  typedef enum logic [3:0] {
    S_IDLE, S_SET, S_ACK, S_START, S_LOCK, S_INIT, S_WAIT, S_TEST, S_DONE, S_FATAL
  } state_t;

  state_t          st;
  logic [SW-1:0]   cur_s, bs;
  logic [DW-1:0]   cur_d, dly, run_st, bst, ben;
  logic [LW-1:0]   run, bl, run_nx;
  logic [PW-1:0]   poll;
  logic [TW-1:0]   tmr;
  logic            fin;
  logic [DW:0]     msum;
  logic            trial_ok;

  assign out_shift = wr_shift + SW'(SHIFT_OFS);
  assign msum      = {1'b0, bst} + {1'b0, ben};
  assign run_nx    = run + LW'(1);
  assign trial_ok  = test_pass && ((ctl_status & ERR_BITS) == '0);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_dly[g*DW +: DW] = dly;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cur_s <= '0; cur_d <= '0; fin <= 1'b0;
      run <= '0; run_st <= '0; bl <= '0; bs <= '0; bst <= '0; ben <= '0;
      poll <= '0; tmr <= '0;
      ctl_start <= 1'b0; err_ack <= '0; test_go <= 1'b0;
      wr_shift <= '0; dly <= '0; cal_done <= 1'b0; fatal <= 1'b0;
      res_shift <= '0; res_dly <= '0; res_len <= '0;
    end else begin
      err_ack <= '0;
      test_go <= 1'b0;
      case (st)
        S_IDLE, S_DONE: if (cal_req) begin
          cal_done <= 1'b0;
          res_shift <= '0; res_dly <= '0; res_len <= '0;
          bl <= '0; bs <= '0; bst <= '0; ben <= '0; run <= '0;
          cur_s <= SW'(SHIFT_FIRST); cur_d <= DW'(DLY_FIRST); fin <= 1'b0;
          st <= S_SET;
        end
        S_SET: begin
          ctl_start <= 1'b0;
          if (fin) begin
            wr_shift <= bs; dly <= msum[DW:1];
            res_shift <= bs; res_dly <= msum[DW:1]; res_len <= bl;
          end else begin
            wr_shift <= cur_s; dly <= cur_d;
          end
          st <= S_ACK;
        end
        S_ACK: begin
          err_ack <= ACK_MASK;
          st <= S_START;
        end
        S_START: begin
          ctl_start <= 1'b1;
          poll <= '0;
          st <= S_LOCK;
        end
        S_LOCK: begin
          if (dll_lock) begin
            poll <= '0; st <= S_INIT;
          end else if (poll == PW'(POLL_MAX - 1)) begin
            fatal <= 1'b1; st <= S_FATAL;
          end else poll <= poll + PW'(1);
        end
        S_INIT: begin
          if (ctl_status[INIT_BIT]) begin
            tmr <= '0; st <= S_WAIT;
          end else if (poll == PW'(POLL_MAX - 1)) begin
            fatal <= 1'b1; st <= S_FATAL;
          end else poll <= poll + PW'(1);
        end
        S_WAIT: begin
          if (tmr == TW'(SETTLE - 1)) begin
            if (fin) begin
              cal_done <= 1'b1; st <= S_DONE;
            end else begin
              test_go <= 1'b1; st <= S_TEST;
            end
          end else tmr <= tmr + TW'(1);
        end
        S_TEST: if (test_done) begin
          if (trial_ok) begin
            run <= run_nx;
            if (run == '0) run_st <= cur_d;
            if (run_nx >= bl) begin
              bl  <= run_nx;
              bs  <= cur_s;
              bst <= (run == '0) ? cur_d : run_st;
              ben <= cur_d;
            end
          end else run <= '0;
          if (cur_d == DW'(DLY_LAST)) begin
            cur_d <= DW'(DLY_FIRST);
            run <= '0;
            if (cur_s == SW'(SHIFT_LAST)) fin <= 1'b1;
            else cur_s <= cur_s + SW'(1);
          end else cur_d <= cur_d + DW'(1);
          st <= S_SET;
        end
        default: st <= S_FATAL;
      endcase
    end
  end

  AST_TEST_UNDER_START: assert property (@(posedge clk) disable iff (!rst_n)
    test_go |-> ctl_start); // R3
  AST_ACK_BEFORE_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctl_start) |-> $past(err_ack) == ACK_MASK); // R3
  AST_SHIFT_MOVE_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(wr_shift) |-> !ctl_start); // R3
  AST_FATAL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    fatal |=> fatal && !cal_done); // R5
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    cal_done && !cal_req |=> $stable(res_shift) && $stable(res_dly) && $stable(res_len)); // R10
  AST_TRIAL_SHIFT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    test_go |-> wr_shift >= SW'(SHIFT_FIRST) && wr_shift <= SW'(SHIFT_LAST)); // R1

endmodule

// File: tb/sim_dqs_eye_search.sv
module sim_dqs_eye_search;
  localparam int SF = 4, SL = 6, OFS = 32, DF = 1, DL = 7, LANES = 3;
  localparam int SW = 8, DW = 3, STW = 8, POLL = 20, SETTLE = 3;
  localparam int NS = SL - SF + 1;

  logic clk = 0, rst_n = 0, cal_req = 0;
  logic ctl_start, dll_lock = 0, test_go, test_done = 0, test_pass = 0;
  logic cal_done, fatal;
  logic [STW-1:0] err_ack, ctl_status;
  logic [SW-1:0] wr_shift, out_shift, res_shift;
  logic [LANES*DW-1:0] lane_dly;
  logic [DW-1:0] res_dly;
  logic [DW:0] res_len;

  logic st6 = 0;
  logic [5:0] errb = 0;
  logic blk_lock = 0, blk_init = 0;
  logic [7:0] pm [NS];
  logic [7:0] em [NS];
  int lk_cnt = 0, in_cnt = 0, tcnt = 0;
  int tot = 0, bad = 0, cyc = 0;
  int exp_s, exp_d, trials, hi6, prev_start;

  assign ctl_status = {1'b1, st6, errb};

  dqs_eye_search #(.SHIFT_FIRST(SF), .SHIFT_LAST(SL), .SHIFT_OFS(OFS), .DLY_FIRST(DF),
    .DLY_LAST(DL), .LANES(LANES), .SW(SW), .DW(DW), .STW(STW), .INIT_BIT(6), .ERRN(6),
    .ACK_MASK(8'h3C), .POLL_MAX(POLL), .SETTLE(SETTLE)) u0 (
    .clk(clk), .rst_n(rst_n), .cal_req(cal_req), .ctl_start(ctl_start), .dll_lock(dll_lock),
    .ctl_status(ctl_status), .err_ack(err_ack), .wr_shift(wr_shift), .out_shift(out_shift),
    .lane_dly(lane_dly), .test_go(test_go), .test_done(test_done), .test_pass(test_pass),
    .cal_done(cal_done), .fatal(fatal), .res_shift(res_shift), .res_dly(res_dly), .res_len(res_len));

  always #4 clk = ~clk;

  function automatic int ix();
    int i = int'(wr_shift) - SF;
    return (i >= 0 && i < NS) ? i : 0;
  endfunction

  always @(posedge clk) begin
    if (!ctl_start) begin lk_cnt <= 0; dll_lock <= 0; end
    else if (lk_cnt == 2) dll_lock <= !blk_lock;
    else lk_cnt <= lk_cnt + 1;
    if (!ctl_start) begin in_cnt <= 0; st6 <= 0; end
    else if (dll_lock) begin
      if (in_cnt == 2) st6 <= !blk_init; else in_cnt <= in_cnt + 1;
    end
    test_done <= 0;
    if (!ctl_start) errb <= 0;
    if (test_go) begin
      tcnt <= 2;
      errb <= em[ix()][lane_dly[DW-1:0]] ? 6'h04 : 6'h00;
    end else if (tcnt != 0) begin
      tcnt <= tcnt - 1;
      if (tcnt == 1) begin test_done <= 1; test_pass <= pm[ix()][lane_dly[DW-1:0]]; end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    tot++;
    if (!ok) begin bad++; $display("FAIL %s actual=%0d expected=%0d", req, act, expv); end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      bad++; $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
      $display("== %0d vectors applied, %0d miscompares ==", tot, bad);
      $finish;
    end
    if (rst_n) begin
      if (st6) hi6++; else hi6 = 0;
      if (ctl_start && !prev_start) chk(prev_start == 0 && $past(err_ack) == 8'h3C, "R3 ack", int'($past(err_ack)), 60);
      if (test_go) begin
        chk(int'(wr_shift) == exp_s, "R1 shift", int'(wr_shift), exp_s);
        chk(int'(lane_dly[DW-1:0]) == exp_d, "R1 delay", int'(lane_dly[DW-1:0]), exp_d);
        chk(int'(out_shift) == exp_s + OFS, "R2 out_shift", int'(out_shift), exp_s + OFS);
        for (int l = 1; l < LANES; l++)
          chk(lane_dly[l*DW +: DW] == lane_dly[DW-1:0], "R2 lanes", int'(lane_dly[l*DW +: DW]), int'(lane_dly[DW-1:0]));
        chk(hi6 == SETTLE + 2 && dll_lock, "R4 settle", hi6, SETTLE + 2);
        if (exp_d == DL) begin exp_d = DF; exp_s++; end else exp_d++;
        trials++;
      end
      prev_start = int'(ctl_start);
    end else prev_start = 0;
  end

  task automatic expect_res(output int es, output int ed, output int el);
    int bl = 0, bs = 0, bst = 0, ben = 0, run, rs = 0;
    for (int s = SF; s <= SL; s++) begin
      run = 0;
      for (int d = DF; d <= DL; d++) begin
        if (pm[s-SF][d] && !em[s-SF][d]) begin
          if (run == 0) rs = d;
          run++;
          if (run >= bl) begin bl = run; bs = s; bst = rs; ben = d; end
        end else run = 0;
      end
    end
    es = bs; ed = (bst + ben) / 2; el = bl;
  endtask

  task automatic do_cal(input string tag, input int poke_at);
    int n = 0, es, ed, el;
    exp_s = SF; exp_d = DF; trials = 0;
    @(negedge clk) cal_req = 1;
    @(negedge clk) cal_req = 0;
    while (!cal_done && !fatal && n < 5000) begin
      @(negedge clk);
      n++;
      cal_req = (n == poke_at);
    end
    cal_req = 0;
    expect_res(es, ed, el);
    chk(cal_done == 1, {tag, " R9 done"}, int'(cal_done), 1);
    chk(trials == NS * (DL - DF + 1), {tag, " R10 R1 trial count"}, trials, NS * (DL - DF + 1));
    chk(int'(res_len) == el, {tag, " R8 R7 R6 res_len"}, int'(res_len), el);
    chk(int'(res_shift) == es, {tag, " R8 res_shift"}, int'(res_shift), es);
    chk(int'(res_dly) == ed, {tag, " R9 res_dly"}, int'(res_dly), ed);
    chk(int'(wr_shift) == es && int'(out_shift) == es + OFS, {tag, " R9 R2 applied shift"}, int'(wr_shift), es);
    chk(int'(lane_dly[DW-1:0]) == ed && ctl_start, {tag, " R9 applied delay"}, int'(lane_dly[DW-1:0]), ed);
    repeat (5) @(negedge clk);
    chk(int'(res_dly) == ed && int'(res_len) == el && cal_done, {tag, " R10 hold"}, int'(res_dly), ed);
  endtask

  task automatic do_reset();
    rst_n = 0;
    repeat (3) @(negedge clk);
    chk(!cal_done && !fatal && !ctl_start && !test_go && wr_shift == 0 && lane_dly == 0
        && res_len == 0 && res_shift == 0 && res_dly == 0, "R12 reset", int'(cal_done), 0);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic do_fatal(input string tag);
    int n = 0;
    @(negedge clk) cal_req = 1;
    @(negedge clk) cal_req = 0;
    while (!fatal && n < 2000) begin @(negedge clk); n++; end
    chk(fatal == 1 && !cal_done, {tag, " R5 fatal"}, int'(fatal), 1);
    chk(int'(wr_shift) == SF && int'(lane_dly[DW-1:0]) == DF, {tag, " R5 held setting"}, int'(wr_shift), SF);
    @(negedge clk) cal_req = 1;
    @(negedge clk) cal_req = 0;
    repeat (40) @(negedge clk);
    chk(fatal == 1 && !cal_done && int'(wr_shift) == SF, {tag, " R5 sticky"}, int'(fatal), 1);
  endtask

  initial begin
    for (int i = 0; i < NS; i++) begin pm[i] = 0; em[i] = 0; end
    do_reset();
    do_cal("nopass R11", 0);
    chk(res_len == 0 && res_shift == 0 && wr_shift == 0 && lane_dly == 0, "R11 zeros", int'(res_len), 0);
    pm[1] = 8'b0011_1100;
    do_cal("window", 60);
    pm[0] = 8'b0000_1110; pm[1] = 0; pm[2] = 8'b1110_0000;
    do_cal("cross tie R8", 0);
    pm[0] = 0; pm[1] = 8'b0110_0110; pm[2] = 0;
    do_cal("inner tie R8", 0);
    for (int i = 0; i < NS; i++) pm[i] = 8'hFE;
    do_cal("all pass R7", 0);
    em[2] = 8'b0001_0000; em[0] = 8'b0000_1000;
    do_cal("err flags R6", 0);
    for (int seed = 0; seed < 16; seed++) begin
      for (int i = 0; i < NS; i++) begin
        pm[i] = 8'((seed * 53 + i * 29 + seed * i * 7) ^ (seed << (i + 1)));
        em[i] = (seed % 4 == 0) ? 8'(1 << ((seed + i) % 8)) : 8'h00;
      end
      do_cal("sweep", (seed == 5) ? 150 : 0);
    end
    blk_lock = 1;
    do_fatal("lock timeout");
    blk_lock = 0;
    do_reset();
    blk_init = 1;
    do_fatal("init timeout");
    blk_init = 0;
    do_reset();
    $display("== %0d vectors applied, %0d miscompares ==", tot, bad);
    $finish;
  end
endmodule